// File: doc/BRIEF.md
# Linked-Descriptor Transmit DMA

This block is a transmit DMA engine. It walks a chain of descriptors held in word-addressed memory and sends the frame bytes they point to, one byte per beat, to a MAC transmit port. Each descriptor is four 32-bit words. An ownership bit in the status word says whether the engine may use the descriptor. A control word carries the byte count, an end-of-frame flag and a chained-mode flag. The other two words are the buffer address and the address of the next descriptor.

Software loads the address of the first descriptor while the engine is idle, sets the enable level and pulses start. The engine then reads a descriptor. If the engine owns it, the engine reads the buffer, writes the status word back with the ownership bit cleared, and moves on to the next descriptor. It stops and goes idle as soon as it reads a descriptor it does not own. Bytes collect in an internal frame store. The frame is sent only after its final descriptor has been fully read and written back (store-and-forward), with first and last markers on the byte stream.

Top module: `txdma_chain`

## Requirements
- R1: After synchronous reset, `busy`, `tx_valid`, `mem_rd` and `mem_we` are 0 and `cur_desc` is 0.
- R2: A `base_we` pulse while idle makes `cur_desc` equal `base_addr` one clock later. A `base_we` pulse while busy leaves `cur_desc` unchanged.
- R3: A start pulse takes effect only when the engine is idle and `dma_en` is 1, and then `busy` is 1 one clock later. Otherwise the pulse has no effect: `busy` stays 0 and memory is left untouched.
- R4: A descriptor at byte address D occupies four words:
  - D+0: status. Bit 31 = 1 means the engine owns the descriptor.
  - D+4: control. Bit 30 marks the final descriptor of a frame, bit 24 selects chained mode, and bits 13:0 hold the byte count. Bit 29 has no effect.
  - D+8: buffer byte address, with bits 1:0 ignored.
  - D+12: next-descriptor address.
- R5: When the status word it reads has bit 31 clear, the engine goes idle without writing memory, and `cur_desc` holds that descriptor's address.
- R6: For an owned descriptor, the engine emits the count bytes starting at the buffer address, little-endian: the byte at address A is bits 8*(A mod 4)+7 down to 8*(A mod 4) of the word at A. It then writes the status word back with only bit 31 cleared.
- R7: The next descriptor address is word D+12 when bit 24 is set, and D+16 when bit 24 is clear.
- R8: No byte of a frame appears on the output before the status of that frame's final descriptor has been written back. A frame is the run of descriptors up to and including one with bit 30 set.
- R9: `tx_first` is 1 on the first byte of each frame and `tx_last` is 1 on its final byte, and on no other byte.
- R10: While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid`, `tx_data`, `tx_first` and `tx_last` hold their values.
- R11: An owned descriptor with byte count 0 emits no byte but still has its ownership bit cleared. A frame with no bytes in total produces no output.
- R12: A frame longer than `FRAME_BYTES` is sent truncated to its first `FRAME_BYTES` bytes, with `tx_last` on the last byte kept. A frame of exactly `FRAME_BYTES` bytes is sent whole.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dma_en | input | 1 | Enable level; start pulses count only while it is 1 |
| start | input | 1 | Start pulse: begin walking at `cur_desc` |
| base_we | input | 1 | Load `base_addr` into the descriptor pointer (idle only) |
| base_addr | input | AW | First descriptor byte address |
| cur_desc | output | AW | Address of the descriptor being handled |
| busy | output | 1 | Engine is walking the chain |
| mem_rd | output | 1 | Memory read request; data is due one clock later |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| tx_valid | output | 1 | Output byte valid |
| tx_data | output | 8 | Output byte |
| tx_first | output | 1 | First byte of a frame |
| tx_last | output | 1 | Final byte of a frame |
| tx_ready | input | 1 | Downstream accepts the byte |

## Verification
`cur_desc` follows a base load after exactly one clock edge. `busy` rises one edge after an accepted start. The bench samples both on the falling edge right after that edge, and samples the ignored-start case at the same point. Byte timing depends on memory latency and on a pseudo-random `tx_ready`, so the bytes are compared in order against a queue computed from the descriptor contents at every falling edge where valid and ready are both high. At the first byte of each frame, the bench reads the final descriptor's status from its memory model to confirm that the write-back has already happened. Write-backs, final pointers and the drained queue are checked once `busy` has fallen.

// File: rtl/txd_pkg.sv
package txd_pkg;
  localparam int OWN_BIT    = 31;
  localparam int LAST_BIT   = 30;
  localparam int CHAIN_BIT  = 24;
  localparam int DESC_BYTES = 16;
  localparam logic [31:0] OWN_MASK = 32'(1) << OWN_BIT;

  typedef enum logic [3:0] {
    S_IDLE, S_DREQ, S_DCAP, S_BREQ, S_BCAP, S_PUSH, S_WB, S_DRAIN, S_NEXT
  } txd_state_e;
endpackage

// File: rtl/txd_frame_buf.sv
module txd_frame_buf #(
  parameter int DEPTH = 2048,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          rd_en,
  input  logic [IW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  logic [7:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= store[rd_addr];
  end
endmodule

// File: rtl/txd_tx_out.sv
module txd_tx_out #(
  parameter int CW = 12,
  parameter int IW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [CW-1:0] flen,
  input  logic          tx_ready,
  output logic          rd_en,
  output logic [IW-1:0] rd_addr,
  output logic          tx_valid,
  output logic          tx_first,
  output logic          tx_last,
  output logic          done
);
  logic [CW-1:0] sent;

  assign rd_en   = go && (sent < flen) && (!tx_valid || tx_ready);
  assign rd_addr = sent[IW-1:0];
  assign done    = tx_valid && tx_ready && tx_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      sent     <= '0;
      tx_valid <= 1'b0;
      tx_first <= 1'b0;
      tx_last  <= 1'b0;
    end else begin
      if (!go)        sent <= '0;
      else if (rd_en) sent <= sent + CW'(1);
      if (rd_en) begin
        tx_valid <= 1'b1;
        tx_first <= (sent == '0);
        tx_last  <= (sent + CW'(1) == flen);
      end else if (tx_ready) begin
        tx_valid <= 1'b0;
        tx_first <= 1'b0;
        tx_last  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/txdma_chain.sv
module txdma_chain
  import txd_pkg::*;
#(
  parameter int AW          = 32,
  parameter int LEN_W       = 14,
  parameter int FRAME_BYTES = 2048
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dma_en,
  input  logic          start,
  input  logic          base_we,
  input  logic [AW-1:0] base_addr,
  output logic [AW-1:0] cur_desc,
  output logic          busy,
  output logic          mem_rd,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          tx_first,
  output logic          tx_last,
  input  logic          tx_ready
);
  localparam int IW = $clog2(FRAME_BYTES);
  localparam int CW = IW + 1;

  txd_state_e      state;
  logic [AW-1:0]   cur;
  logic [1:0]      widx;
  logic [31:0]     d_status;
  logic            d_last, d_chain;
  logic [LEN_W-1:0] d_len, rem;
  logic [AW-3:0]   d_buf;
  logic [AW-1:0]   d_next, baddr;
  logic [1:0]      bsel;
  logic [31:0]     word_sh;
  logic [CW-1:0]   fcnt;

  logic            room, wr_en, rd_en, frame_done;
  logic [IW-1:0]   rd_addr;

  assign room     = fcnt < CW'(FRAME_BYTES);
  assign wr_en    = (state == S_PUSH) && room;
  assign cur_desc = cur;
  assign busy     = (state != S_IDLE);

  always_comb begin
    mem_rd    = (state == S_DREQ) || (state == S_BREQ);
    mem_we    = (state == S_WB);
    mem_wdata = d_status & ~OWN_MASK;
    if (state == S_BREQ) mem_addr = baddr;
    else if (state == S_DREQ) mem_addr = cur + AW'({widx, 2'b00});
    else mem_addr = cur;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      cur      <= '0;
      widx     <= '0;
      d_status <= '0;
      d_last   <= 1'b0;
      d_chain  <= 1'b0;
      d_len    <= '0;
      d_buf    <= '0;
      d_next   <= '0;
      baddr    <= '0;
      rem      <= '0;
      bsel     <= '0;
      word_sh  <= '0;
      fcnt     <= '0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (base_we) cur <= base_addr;
          if (start && dma_en) begin
            widx  <= '0;
            state <= S_DREQ;
          end
        end
        S_DREQ: state <= S_DCAP;
        S_DCAP: begin
          unique case (widx)
            2'd0: begin
              d_status <= mem_rdata;
              if (mem_rdata[OWN_BIT]) begin
                widx  <= 2'd1;
                state <= S_DREQ;
              end else begin
                state <= S_IDLE;
              end
            end
            2'd1: begin
              d_last  <= mem_rdata[LAST_BIT];
              d_chain <= mem_rdata[CHAIN_BIT];
              d_len   <= mem_rdata[LEN_W-1:0];
              widx    <= 2'd2;
              state   <= S_DREQ;
            end
            2'd2: begin
              d_buf <= mem_rdata[AW-1:2];
              widx  <= 2'd3;
              state <= S_DREQ;
            end
            default: begin
              d_next <= mem_rdata[AW-1:0];
              baddr  <= {d_buf, 2'b00};
              rem    <= d_len;
              bsel   <= '0;
              state  <= (d_len == '0) ? S_WB : S_BREQ;
            end
          endcase
        end
        S_BREQ: state <= S_BCAP;
        S_BCAP: begin
          word_sh <= mem_rdata;
          state   <= S_PUSH;
        end
        S_PUSH: begin
          word_sh <= {8'h00, word_sh[31:8]};
          if (room) fcnt <= fcnt + CW'(1);
          rem  <= rem - LEN_W'(1);
          bsel <= bsel + 2'd1;
          if (rem == LEN_W'(1)) begin
            state <= S_WB;
          end else if (bsel == 2'd3) begin
            baddr <= baddr + AW'(4);
            state <= S_BREQ;
          end
        end
        S_WB: begin
          if (d_last && fcnt != '0) state <= S_DRAIN;
          else                      state <= S_NEXT;
        end
        S_DRAIN: begin
          if (frame_done) begin
            fcnt  <= '0;
            state <= S_NEXT;
          end
        end
        default: begin
          cur   <= d_chain ? d_next : cur + AW'(DESC_BYTES);
          widx  <= '0;
          state <= S_DREQ;
        end
      endcase
    end
  end

  txd_frame_buf #(.DEPTH(FRAME_BYTES), .IW(IW)) u_buf (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (fcnt[IW-1:0]),
    .wr_data (word_sh[7:0]),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (tx_data)
  );

  txd_tx_out #(.CW(CW), .IW(IW)) u_out (
    .clk      (clk),
    .rst      (rst),
    .go       (state == S_DRAIN),
    .flen     (fcnt),
    .tx_ready (tx_ready),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .tx_valid (tx_valid),
    .tx_first (tx_first),
    .tx_last  (tx_last),
    .done     (frame_done)
  );
endmodule

// File: rtl/txdma_chain_chk.sv
module txdma_chain_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          dma_en,
  input logic          base_we,
  input logic [AW-1:0] base_addr,
  input logic [AW-1:0] cur_desc,
  input logic          busy,
  input logic          mem_rd,
  input logic          mem_we,
  input logic          wb_own,
  input logic          tx_valid,
  input logic [7:0]    tx_data,
  input logic          tx_first,
  input logic          tx_last,
  input logic          tx_ready
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mem_rd && !mem_we));

  assert_base_load_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy && base_we) |=> (cur_desc == $past(base_addr)));

  assert_start_gated_R3: assert property (@(posedge clk) disable iff (rst)
    (!busy && !dma_en) |=> !busy);

  assert_one_access_R4: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> !mem_we);

  assert_wb_releases_R6: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !wb_own);

  assert_out_only_busy_R8: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> busy);

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) &&
                                 $stable(tx_first) && $stable(tx_last)));
endmodule

bind txdma_chain txdma_chain_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .dma_en    (dma_en),
  .base_we   (base_we),
  .base_addr (base_addr),
  .cur_desc  (cur_desc),
  .busy      (busy),
  .mem_rd    (mem_rd),
  .mem_we    (mem_we),
  .wb_own    (mem_wdata[31]),
  .tx_valid  (tx_valid),
  .tx_data   (tx_data),
  .tx_first  (tx_first),
  .tx_last   (tx_last),
  .tx_ready  (tx_ready)
);

// File: tb/tb_txdma_chain.sv
`timescale 1ns/1ps
module tb_txdma_chain;
  localparam int AW = 12;
  localparam int FB = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dma_en = 1'b0, start = 1'b0, base_we = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic [AW-1:0] cur_desc, mem_addr;
  logic busy, mem_rd, mem_we, tx_valid, tx_first, tx_last;
  logic tx_ready = 1'b0;
  logic [31:0] mem_wdata, mem_rdata;
  logic [7:0] tx_data;

  always #2 clk = ~clk;

  txdma_chain #(.AW(AW), .LEN_W(14), .FRAME_BYTES(FB)) dut (
    .clk(clk), .rst(rst), .dma_en(dma_en), .start(start),
    .base_we(base_we), .base_addr(base_addr), .cur_desc(cur_desc), .busy(busy),
    .mem_rd(mem_rd), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_first(tx_first),
    .tx_last(tx_last), .tx_ready(tx_ready)
  );

  logic [31:0] mem [0:1023];
  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[11:2]];
    if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
  end

  logic [15:0] lfsr = 16'hACE1;
  always @(posedge clk) begin
    lfsr     <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tx_ready <= lfsr[0] | lfsr[2];
  end

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int a);
    int v;
    v = (a * 37 + 11) ^ (a >> 5);
    return v[7:0];
  endfunction

  // expected byte queue
  logic [7:0] exp_data [0:2047];
  bit         exp_first [0:2047];
  bit         exp_last  [0:2047];
  int         exp_ld    [0:2047];
  int exp_wr = 0, exp_rd = 0, fr_start = 0;

  task automatic fr_open();
    fr_start = exp_wr;
  endtask

  task automatic fr_add(input int bufa, input int len);
    for (int i = 0; i < len; i++) begin
      if (exp_wr - fr_start < FB) begin
        exp_data[exp_wr]  = pat(bufa + i);
        exp_first[exp_wr] = 0;
        exp_last[exp_wr]  = 0;
        exp_wr++;
      end
    end
  endtask

  task automatic fr_close(input int ld);
    if (exp_wr > fr_start) begin
      exp_first[fr_start] = 1;
      exp_last[exp_wr-1]  = 1;
      exp_ld[fr_start]    = ld;
    end
  endtask

  // output monitor
  bit prev_hold = 0;
  logic [7:0] prev_data;
  logic prev_first, prev_last;
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_hold)
        chk(tx_valid && tx_data == prev_data && tx_first == prev_first &&
            tx_last == prev_last, "R10", "held output",
            {tx_valid, tx_first, tx_last, tx_data}, {1'b1, prev_first, prev_last, prev_data});
      prev_hold  = tx_valid && !tx_ready;
      prev_data  = tx_data;
      prev_first = tx_first;
      prev_last  = tx_last;
      if (tx_valid && tx_ready) begin
        if (exp_rd >= exp_wr) begin
          chk(0, "R6", "unexpected byte", tx_data, 0);
        end else begin
          chk(tx_data == exp_data[exp_rd], "R6", "byte value", tx_data, exp_data[exp_rd]);
          chk(tx_first == exp_first[exp_rd] && tx_last == exp_last[exp_rd],
              "R9", "first/last markers", {tx_first, tx_last},
              {exp_first[exp_rd], exp_last[exp_rd]});
          if (exp_first[exp_rd])
            chk(mem[exp_ld[exp_rd] >> 2][31] == 1'b0, "R8",
                "final status written before first byte",
                mem[exp_ld[exp_rd] >> 2], 0);
          exp_rd++;
        end
      end
    end
  end

  localparam logic [31:0] ST_OWN  = 32'h8000_005A;
  localparam logic [31:0] ST_DONE = 32'h0000_005A;

  task automatic put_desc(input int a, input bit own, input bit last,
                          input bit chain, input int len, input int bufa, input int nxt);
    mem[a >> 2]       = own ? ST_OWN : 32'h0000_0000;
    mem[(a >> 2) + 1] = (32'(last) << 30) | (32'(chain) << 24) | 32'h2000_0000 | 32'(len);
    mem[(a >> 2) + 2] = 32'(bufa);
    mem[(a >> 2) + 3] = 32'(nxt);
  endtask

  task automatic load_base(input int a);
    @(negedge clk); base_we = 1; base_addr = AW'(a);
    @(negedge clk); base_we = 0;
    chk(int'(cur_desc) == a, "R2", "pointer after base load", cur_desc, a);
  endtask

  task automatic kick();
    start = 1;
    @(negedge clk); start = 0;
    chk(busy == dma_en, "R3", "busy after start", busy, dma_en);
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(!busy, "R5", "engine returned to idle", busy, 0);
    chk(exp_rd == exp_wr, "R9", "all expected bytes sent", exp_rd, exp_wr);
  endtask

  task automatic chk_status(input int a, input string req);
    chk(mem[a >> 2] == ST_DONE, req, "status written back", mem[a >> 2], ST_DONE);
  endtask

  initial begin
    for (int w = 512; w < 1024; w++)
      mem[w] = {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)};
    for (int w = 0; w < 512; w++) mem[w] = 32'h0;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!busy && !tx_valid && !mem_rd && !mem_we, "R1", "idle outputs after reset",
        {busy, tx_valid, mem_rd, mem_we}, 0);
    chk(cur_desc == '0, "R1", "pointer after reset", cur_desc, 0);

    // start while disabled: ignored
    put_desc(32'h000, 1, 1, 1, 2, 32'h800, 32'h010);
    load_base(32'h000);
    kick();
    repeat (20) @(negedge clk);
    chk(!busy, "R3", "disabled start leaves engine idle", busy, 0);
    chk(mem[0] == ST_OWN, "R3", "disabled start leaves memory", mem[0], ST_OWN);
    dma_en = 1;

    // length sweep, one descriptor per frame
    for (int len = 1; len <= 24; len++) begin
      put_desc(32'h100, 1, 1, 1, len, 32'h800 + len*16, 32'h110);
      put_desc(32'h110, 0, 1, 1, 4, 32'h800, 32'h100);
      fr_open(); fr_add(32'h800 + len*16, len); fr_close(32'h100);
      load_base(32'h100);
      kick();
      wait_idle();
      chk_status(32'h100, "R4 R6");
      chk(mem[32'h110 >> 2] == 32'h0, "R5", "unowned descriptor untouched", mem[32'h110 >> 2], 0);
      chk(int'(cur_desc) == 32'h110, "R5", "pointer at unowned descriptor", cur_desc, 32'h110);
    end

    // two-descriptor frame, chained pointers
    put_desc(32'h200, 1, 0, 1, 3, 32'h900, 32'h300);
    put_desc(32'h300, 1, 1, 1, 6, 32'h940, 32'h240);
    put_desc(32'h240, 0, 0, 1, 1, 32'h900, 32'h200);
    fr_open(); fr_add(32'h900, 3); fr_add(32'h940, 6); fr_close(32'h300);
    load_base(32'h200);
    kick();
    wait_idle();
    chk_status(32'h200, "R8");
    chk_status(32'h300, "R8");
    chk(int'(cur_desc) == 32'h240, "R7", "chained pointer followed", cur_desc, 32'h240);

    // unchained: next is address + 16, next field ignored
    put_desc(32'h400, 1, 1, 0, 4, 32'hA00, 32'h7F0);
    put_desc(32'h410, 1, 1, 0, 2, 32'hA10, 32'h7F0);
    put_desc(32'h420, 0, 1, 0, 1, 32'hA00, 32'h400);
    put_desc(32'h7F0, 1, 1, 1, 1, 32'hA80, 32'h420);
    fr_open(); fr_add(32'hA00, 4); fr_close(32'h400);
    fr_open(); fr_add(32'hA10, 2); fr_close(32'h410);
    load_base(32'h400);
    kick();
    wait_idle();
    chk_status(32'h410, "R7");
    chk(int'(cur_desc) == 32'h420, "R7", "sequential pointer", cur_desc, 32'h420);
    chk(mem[32'h7F0 >> 2] == ST_OWN, "R7", "next field ignored", mem[32'h7F0 >> 2], ST_OWN);

    // zero-length descriptors
    put_desc(32'h500, 1, 1, 1, 0, 32'hB00, 32'h510);
    put_desc(32'h510, 1, 0, 1, 0, 32'hB00, 32'h520);
    put_desc(32'h520, 1, 1, 1, 2, 32'hB00, 32'h530);
    put_desc(32'h530, 0, 1, 1, 0, 32'hB00, 32'h500);
    fr_open(); fr_add(32'hB00, 2); fr_close(32'h520);
    load_base(32'h500);
    kick();
    wait_idle();
    chk_status(32'h500, "R11");
    chk_status(32'h510, "R11");
    chk_status(32'h520, "R11");

    // 66-byte frame in a wrapping ring, base load while busy
    put_desc(32'h600, 1, 0, 1, 30, 32'hC00, 32'h610);
    put_desc(32'h610, 1, 0, 1, 30, 32'hC40, 32'h620);
    put_desc(32'h620, 1, 1, 1, 6,  32'hC80, 32'h600);
    fr_open(); fr_add(32'hC00, 30); fr_add(32'hC40, 30); fr_add(32'hC80, 6); fr_close(32'h620);
    load_base(32'h600);
    kick();
    base_we = 1; base_addr = '0;
    @(negedge clk); base_we = 0;
    wait_idle();
    chk_status(32'h620, "R12");
    chk(int'(cur_desc) == 32'h600, "R2", "busy base load ignored, ring wrapped", cur_desc, 32'h600);

    // exactly FRAME_BYTES
    put_desc(32'h700, 1, 1, 1, 64, 32'hD00, 32'h710);
    put_desc(32'h710, 0, 1, 1, 0, 32'hD00, 32'h700);
    fr_open(); fr_add(32'hD00, 64); fr_close(32'h700);
    load_base(32'h700);
    kick();
    wait_idle();
    chk_status(32'h700, "R12");

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule